// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block turns general-purpose input pins into interrupt requests. Pins come in banks of 32 lines. Software gives each line a 4-bit trigger code: rising edge, falling edge, both edges, high level or low level. Each line also has an enable bit and a latched status bit that software clears by writing a 1. The block passes every pin through a two-flop synchronizer and compares the present synchronized sample with the one before it. When the chosen condition holds, it sets the line's status bit. Each bank drives one interrupt output, which is the OR of the lines that are both pending and enabled.

Software reaches the block through a plain 32-bit register bus with a byte address, write data, write enable, read enable and registered read data. Each bank has a 32-byte window at offset 0x200 plus 0x20 times its slot number. A build-time parameter maps each logical bank to its physical slot, so a bank's registers can be moved without changing the pins it serves. The window also holds a debounce word. The block only stores this word; it does not use it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and every `irqOut` bit is low.
- R2: Window layout, byte offsets relative to the window start:
  - 0x00, 0x04, 0x08 and 0x0C are trigger words. Word w covers lines 8w to 8w+7, and line n sits in bits [(n%8)*4+3 : (n%8)*4].
  - 0x10 is the enable word, with bit n for line n.
  - 0x14 is the status word, with bit n for line n.
  - 0x18 is the debounce word.
  - `rdData` takes the addressed value on the clock edge where `rdEn` is high, and otherwise holds its value.
- R3: The window for logical bank b starts at 0x200 + 0x20 × `BANK_SLOT[4b+3:4b]`.
- R4: Some accesses are unmapped:
  - addresses below 0x200;
  - addresses whose slot is assigned to no bank;
  - offset 0x1C inside a window;
  - addresses that are not 4-byte aligned.
  Reads of an unmapped address return zero, and writes to one change nothing.
- R5: Edge codes are 0 for rising, 1 for falling and 4 for both. They compare two successive synchronized samples. A pin change made before clock edge k sets the status bit on edge k+2. It is therefore visible after the third edge counted from the capture edge.
- R6: Level codes are 2 for high and 3 for low. The status bit is set on every cycle in which the condition holds, so it comes back right after a clear.
- R7: Codes 5 to 15 never set a status bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear keeps the bit set.
- R9: A status bit latches whether or not its line is enabled. `irqOut[b]` is high exactly when bank b has a line that is both pending and enabled.
- R10: The debounce word reads back what was written and has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| pinIn | input | NUM_BANKS*32 | Asynchronous pin levels, bank b at bits [32b+31:32b] |
| irqOut | output | NUM_BANKS | Per-bank interrupt request |

## Verification
Random trials choose a bank, a line, a trigger code (every one of the 16 codes in turn, then at random), an enable bit, a pin level before the clear and a pin level after it. This set of trials separates each edge direction from the both-edges code, and it separates level codes, whose status comes back after a clear, from edge codes, whose status does not. It also confirms that reserved codes stay silent.

Directed cases cover the following:
- the exact three-edge latency;
- a write of 0 to the status word against a write of 1;
- a clear while a level condition holds;
- unmapped reads and writes;
- the swapped bank-to-slot map used by the bench, which shows that both banks' windows follow the map.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int LINES = 32;
  localparam int CFG_WORDS = 4;
  localparam int LINES_PER_WORD = LINES / CFG_WORDS;
  localparam int MODE_W = 4;
  localparam int WIN_BASE = 32'h200;
  localparam int WIN_SHIFT = 5;

  typedef enum logic [2:0] {
    SEL_CFG0 = 3'd0,
    SEL_CFG1 = 3'd1,
    SEL_CFG2 = 3'd2,
    SEL_CFG3 = 3'd3,
    SEL_EN   = 3'd4,
    SEL_STS  = 3'd5,
    SEL_DB   = 3'd6,
    SEL_NONE = 3'd7
  } regSel_t;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_t;

  typedef struct packed {
    logic [CFG_WORDS-1:0] cfgWr;
    logic enWr;
    logic clrWr;
    logic dbWr;
  } bankStb_t;

  typedef struct packed {
    logic hit;
    regSel_t sel;
  } rdPick_t;
endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W = 12,
  parameter logic [NUM_BANKS*4-1:0] BANK_SLOT = 8'h10,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  output bankStb_t [NUM_BANKS-1:0] wrStb,
  output rdPick_t rdPick,
  output logic [BANK_W-1:0] rdBank
);
  logic [ADDR_W-1:0] winOff;
  logic inRange;
  logic slotMatch;
  logic [2:0] inner;
  logic [BANK_W-1:0] bankSel;
  logic hit;

  assign winOff  = addr - ADDR_W'(WIN_BASE);
  assign inRange = (addr >= ADDR_W'(WIN_BASE)) && (addr[1:0] == 2'b00);
  assign inner   = winOff[4:2];

  always_comb begin
    slotMatch = 1'b0;
    bankSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (winOff[ADDR_W-1:WIN_SHIFT] ==
          {{(ADDR_W-WIN_SHIFT-4){1'b0}}, BANK_SLOT[b*4 +: 4]}) begin
        slotMatch = 1'b1;
        bankSel = BANK_W'(b);
      end
    end
  end

  assign hit = inRange && slotMatch && (inner != 3'd7);

  assign rdPick.hit = hit;
  assign rdPick.sel = hit ? regSel_t'(inner) : SEL_NONE;
  assign rdBank = bankSel;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stb
      logic bankWr;
      assign bankWr = wrEn && hit && (bankSel == BANK_W'(b));
      for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg
        assign wrStb[b].cfgWr[k] = bankWr && (inner == 3'(k));
      end
      assign wrStb[b].enWr  = bankWr && (inner == 3'd4);
      assign wrStb[b].clrWr = bankWr && (inner == 3'd5);
      assign wrStb[b].dbWr  = bankWr && (inner == 3'd6);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ALL_LINES = NUM_BANKS * LINES
) (
  input  logic clk,
  input  logic rst,
  input  logic [31:0] wrData,
  input  logic rdEn,
  input  bankStb_t [NUM_BANKS-1:0] wrStb,
  input  rdPick_t rdPick,
  input  logic [BANK_W-1:0] rdBank,
  input  logic [ALL_LINES-1:0] pinIn,
  output logic [31:0] rdData,
  output logic [NUM_BANKS-1:0] irqOut,
  output logic [ALL_LINES-1:0] stsFlat,
  output logic [ALL_LINES-1:0] enFlat,
  output logic [ALL_LINES-1:0] evtFlat
);
  logic [NUM_BANKS*CFG_WORDS*32-1:0] cfgFlat;
  logic [NUM_BANKS*32-1:0] dbFlat;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [LINES-1:0] syncA, syncB, prevQ;
      logic [CFG_WORDS-1:0][31:0] cfgQ;
      logic [LINES-1:0] enQ, stsQ, evt;
      logic [31:0] dbQ;

      always_ff @(posedge clk) begin
        if (rst) begin
          syncA <= '0;
          syncB <= '0;
          prevQ <= '0;
          cfgQ  <= '0;
          enQ   <= '0;
          stsQ  <= '0;
          dbQ   <= '0;
        end else begin
          syncA <= pinIn[b*LINES +: LINES];
          syncB <= syncA;
          prevQ <= syncB;
          for (int k = 0; k < CFG_WORDS; k++) begin
            if (wrStb[b].cfgWr[k]) cfgQ[k] <= wrData;
          end
          if (wrStb[b].enWr) enQ <= wrData;
          if (wrStb[b].dbWr) dbQ <= wrData;
          if (wrStb[b].clrWr) stsQ <= (stsQ & ~wrData) | evt;
          else stsQ <= stsQ | evt;
        end
      end

      for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [MODE_W-1:0] mode;
        assign mode = cfgQ[i / LINES_PER_WORD][(i % LINES_PER_WORD)*MODE_W +: MODE_W];
        always_comb begin
          case (mode)
            TRIG_RISE: evt[i] = syncB[i] & ~prevQ[i];
            TRIG_FALL: evt[i] = ~syncB[i] & prevQ[i];
            TRIG_HIGH: evt[i] = syncB[i];
            TRIG_LOW:  evt[i] = ~syncB[i];
            TRIG_BOTH: evt[i] = syncB[i] ^ prevQ[i];
            default:   evt[i] = 1'b0;
          endcase
        end
      end

      assign irqOut[b] = |(stsQ & enQ);
      assign stsFlat[b*LINES +: LINES] = stsQ;
      assign enFlat[b*LINES +: LINES]  = enQ;
      assign evtFlat[b*LINES +: LINES] = evt;
      assign cfgFlat[b*CFG_WORDS*32 +: CFG_WORDS*32] = cfgQ;
      assign dbFlat[b*32 +: 32] = dbQ;
    end
  endgenerate

  logic [31:0] rdMux;
  always_comb begin
    case (rdPick.sel)
      SEL_CFG0, SEL_CFG1, SEL_CFG2, SEL_CFG3:
        rdMux = cfgFlat[(int'(rdBank)*CFG_WORDS + int'(rdPick.sel))*32 +: 32];
      SEL_EN:  rdMux = enFlat[int'(rdBank)*LINES +: LINES];
      SEL_STS: rdMux = stsFlat[int'(rdBank)*LINES +: LINES];
      SEL_DB:  rdMux = dbFlat[int'(rdBank)*32 +: 32];
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (rdEn) rdData <= rdPick.hit ? rdMux : '0;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W = 12,
  parameter logic [NUM_BANKS*4-1:0] BANK_SLOT = 8'h10,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ALL_LINES = NUM_BANKS * LINES
) (
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wrData,
  input  logic wrEn,
  input  logic rdEn,
  output logic [31:0] rdData,
  input  logic [ALL_LINES-1:0] pinIn,
  output logic [NUM_BANKS-1:0] irqOut
);
  bankStb_t [NUM_BANKS-1:0] wrStb;
  rdPick_t rdPick;
  logic [BANK_W-1:0] rdBank;
  logic [ALL_LINES-1:0] stsFlat, enFlat, evtFlat;

  gpio_irq_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_SLOT(BANK_SLOT)
  ) decode_i (
    .addr(addr), .wrEn(wrEn), .wrStb(wrStb), .rdPick(rdPick), .rdBank(rdBank)
  );

  gpio_irq_datapath #(.NUM_BANKS(NUM_BANKS)) datapath_i (
    .clk(clk), .rst(rst), .wrData(wrData), .rdEn(rdEn), .wrStb(wrStb),
    .rdPick(rdPick), .rdBank(rdBank), .pinIn(pinIn), .rdData(rdData),
    .irqOut(irqOut), .stsFlat(stsFlat), .enFlat(enFlat), .evtFlat(evtFlat)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int ALL_LINES = NUM_BANKS * LINES
) (
  input logic clk,
  input logic rst,
  input logic wrEn,
  input logic rdEn,
  input logic [31:0] rdData,
  input logic [NUM_BANKS-1:0] irqOut,
  input rdPick_t rdPick,
  input logic [ALL_LINES-1:0] stsFlat,
  input logic [ALL_LINES-1:0] enFlat,
  input logic [ALL_LINES-1:0] evtFlat
);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !rdPick.hit) |=> (rdData == 32'd0));

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(stsFlat) & ~stsFlat)) |-> $past(wrEn));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(evtFlat) & ~stsFlat) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (enFlat == '0) |-> (irqOut == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (.*);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int NB = 2;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [31:0] rdData;
  logic [NB*32-1:0] pins = '0;
  logic [NB-1:0] irqOut;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .BANK_SLOT(8'h01)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pins), .irqOut(irqOut)
  );

  // bench map: bank 0 lives in slot 1, bank 1 in slot 0
  function automatic logic [AW-1:0] winBase(int bank);
    return AW'(12'h200 + ((bank == 0) ? 32 : 0));
  endfunction

  function automatic logic expSts(int mode, logic a, logic b);
    case (mode)
      0: return !a && b;
      1: return a && !b;
      2: return a || b;
      3: return !a || !b;
      4: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7341));
    waitCycles(3);
    rst = 1'b0;
    waitCycles(1);

    // R1 reset state
    check(32'(irqOut), 32'd0, "R1 irqOut");
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 7; r++) begin
        busRead(winBase(b) + AW'(r*4), v);
        check(v, 32'd0, "R1 reg");
      end

    // R2 R3 readback through the remapped windows
    busWrite(winBase(0) + 12'h08, 32'h0000_0040);
    busWrite(winBase(1) + 12'h10, 32'hA5A5_0003);
    busWrite(winBase(0) + 12'h18, 32'h1234_5678);
    busRead(winBase(0) + 12'h08, v); check(v, 32'h0000_0040, "R3 bank0 cfg2");
    busRead(winBase(1) + 12'h08, v); check(v, 32'd0, "R3 bank1 cfg2");
    busRead(winBase(1) + 12'h10, v); check(v, 32'hA5A5_0003, "R2 bank1 enable");
    busRead(winBase(0) + 12'h18, v); check(v, 32'h1234_5678, "R10 debounce");
    // R2 rdData holds while rdEn low
    waitCycles(2);
    check(rdData, 32'h1234_5678, "R2 hold");

    // R4 unmapped accesses
    busWrite(winBase(0) + 12'h1C, 32'hFFFF_FFFF);
    busWrite(12'h100, 32'hFFFF_FFFF);
    busWrite(12'h240, 32'hFFFF_FFFF);
    busWrite(winBase(0) + 12'h19, 32'hFFFF_FFFF);
    busRead(winBase(0) + 12'h1C, v); check(v, 32'd0, "R4 offset 0x1C");
    busRead(12'h100, v); check(v, 32'd0, "R4 below window");
    busRead(12'h240, v); check(v, 32'd0, "R4 unassigned slot");
    busRead(winBase(0) + 12'h18, v); check(v, 32'h1234_5678, "R4 write ignored");
    busRead(winBase(1) + 12'h10, v); check(v, 32'hA5A5_0003, "R4 enable untouched");
    busRead(winBase(0) + 12'h10, v); check(v, 32'd0, "R4 bank0 enable untouched");

    // clear the setup
    busWrite(winBase(0) + 12'h08, 32'd0);
    busWrite(winBase(1) + 12'h10, 32'd0);
    waitCycles(4);
    busWrite(winBase(0) + 12'h14, 32'hFFFF_FFFF);
    busWrite(winBase(1) + 12'h14, 32'hFFFF_FFFF);

    // R5 latency: rising edge on bank 1 line 5, enabled
    busWrite(winBase(1) + 12'h10, 32'h20);
    @(negedge clk);
    pins[32+5] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(32'(irqOut), 32'd0, "R5 not yet after two edges");
    @(posedge clk); #1;
    check(32'(irqOut), 32'd2, "R5 set after third edge");

    // R8 writing zero has no effect, writing one clears
    busWrite(winBase(1) + 12'h14, 32'd0);
    busRead(winBase(1) + 12'h14, v); check(v, 32'h20, "R8 write zero");
    busWrite(winBase(1) + 12'h14, 32'h20);
    busRead(winBase(1) + 12'h14, v); check(v, 32'd0, "R8 write one clears");
    check(32'(irqOut), 32'd0, "R9 irq drops after clear");

    // R6 R8 clear while high level holds: event wins
    busWrite(winBase(1) + 12'h00, 32'h0020_0000);
    waitCycles(2);
    busWrite(winBase(1) + 12'h14, 32'h20);
    busRead(winBase(1) + 12'h14, v); check(v, 32'h20, "R6 level returns after clear");
    check(32'(irqOut), 32'd2, "R9 irq with level");
    busWrite(winBase(1) + 12'h00, 32'd0);
    busWrite(winBase(1) + 12'h10, 32'd0);
    pins = '0;
    waitCycles(4);
    busWrite(winBase(1) + 12'h14, 32'hFFFF_FFFF);

    // R5 R6 R7 R9 random trials
    for (int t = 0; t < 64; t++) begin
      int bank, line, mode;
      logic a, b, en, e;
      bank = int'($urandom % 2);
      line = int'($urandom % 32);
      mode = (t < 16) ? t : int'($urandom % 16);
      a = 1'($urandom % 2);
      b = 1'($urandom % 2);
      en = 1'($urandom % 2);
      e = expSts(mode, a, b);
      busWrite(winBase(bank) + AW'((line / 8) * 4), 32'(mode) << ((line % 8) * 4));
      busWrite(winBase(bank) + 12'h10, 32'(en) << line);
      @(negedge clk); pins[bank*32 + line] = a;
      waitCycles(4);
      busWrite(winBase(bank) + 12'h14, 32'hFFFF_FFFF);
      @(negedge clk); pins[bank*32 + line] = b;
      waitCycles(4);
      busRead(winBase(bank) + 12'h14, v);
      if (mode >= 5) check(v, 32'd0, "R7 reserved code");
      else if (mode == 2 || mode == 3) check(v, 32'(e) << line, "R6 level status");
      else check(v, 32'(e) << line, "R5 edge status");
      check(32'(irqOut), 32'(e && en) << bank, "R9 irq enable gating");
      busWrite(winBase(bank) + AW'((line / 8) * 4), 32'd0);
      busWrite(winBase(bank) + 12'h10, 32'd0);
      pins = '0;
      waitCycles(4);
      busWrite(winBase(bank) + 12'h14, 32'hFFFF_FFFF);
    end

    // R10 debounce word has no effect on detection
    busRead(winBase(1) + 12'h14, v); check(v, 32'd0, "R10 status idle");
    busRead(winBase(0) + 12'h18, v); check(v, 32'h1234_5678, "R10 debounce kept");

    finish();
  end
endmodule